// File: doc/BRIEF.md
# Fuse Image Record Unpacker

This block rebuilds a byte-addressed logical configuration map from a packed fuse image. The packed image sits in a synchronous RAM and is read one byte at a time. The logical map is a separate byte RAM that the block fills through a plain write port. A pulse on `start` triggers a run. The run first erases every logical byte to 0xFF. It then walks the packed records and copies each 16-bit word that is present to its fixed place in the logical map.

Each record is a pair of header bytes followed by up to four data words. The header carries an 8-bit block index, split across both bytes, and a 4-bit mask of absent words. Block `b` covers logical bytes `8*b` to `8*b+7`, and word `i` of that block lands at `8*b + 2*i`. A header byte equal to 0xFF marks the end of the data, and so does reaching the end of the usable window. Both are normal finishes. A word that would run past the physical window, or past the logical map, ends the run with an error.

The walk begins at an offset equal to the size of a reserved region at the front of the image. The usable window ends the same distance before the end of the image. Both the sizes and the logical map size are inputs that are sampled when a run is accepted.

Top module: `fuse_map_unpacker`

## Requirements
- R1: After an accepted start, the block writes 0xFF to logical addresses 0 up to `log_size-1`, one per cycle in increasing order, before any decoded write. With `log_size` = 0 it makes no erase writes.
- R2: Record parsing begins at physical index `sec_size`. A new record is begun only while the index is below the limit `phy_size - sec_size`, and that limit is taken as 0 when `phy_size <= sec_size`. Reaching the limit at a record boundary ends the run normally.
- R3: If header byte 1 (at the index) or header byte 2 (at index+1) equals 0xFF, the run ends with `done` and with `error` low.
- R4: The block index is header byte 1 bits [3:0] as its upper nibble, joined to header byte 2 bits [7:4] as its lower nibble. Bits [7:4] of header byte 1 are ignored.
- R5: Header byte 2 bits [3:0] form the absent mask. Bit i = 1 skips word i and consumes no physical bytes. Bit i = 0 means word i is present.
- R6: Present words are handled in order i = 0..3. Word i copies the physical bytes at index and index+1 to logical addresses `8*blk + 2*i` and `8*blk + 2*i + 1`, lower address first. The index advances by 2 after the header and by 2 after each present word.
- R7: If a present word has `index + 2 > limit`, the run stops with an error before that word is written.
- R8: If a present word has logical address `+ 2 > log_size`, the run stops with an error before that word is written. No logical write ever goes to an address at or above `log_size`.
- R9: `done` is high for exactly one cycle at the end of each run. `error` rises only together with `done`, stays high until the next accepted start, and is low from the cycle after that start.
- R10: The physical port has a one-cycle latency. The byte addressed while `phy_rd_en` is high is taken from `phy_rd_data` in the next cycle.
- R11: A `start` while a run is in progress is ignored. While idle, the block drives no read and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| sec_size | input | PHY_AW+1 | Reserved region size at each end of the image |
| phy_size | input | PHY_AW+1 | Total packed image size in bytes |
| log_size | input | LOG_AW+1 | Logical map size in bytes |
| phy_rd_en | output | 1 | Physical read request |
| phy_rd_addr | output | PHY_AW | Physical read address |
| phy_rd_data | input | 8 | Physical read data, valid one cycle after the request |
| log_wr_en | output | 1 | Logical write strobe |
| log_wr_addr | output | LOG_AW | Logical write address |
| log_wr_data | output | 8 | Logical write data |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run ended on a bounds violation |

## Verification
The first erase write appears in the cycle after the edge that samples `start`. Each decoded byte is written one cycle after its physical read is issued, and `error` is set on the same edge that raises `done`. Only the order and content of logical writes are fixed, not their exact cycles, because absent words each take a cycle. For that reason the scoreboard checks the writes as a sequence, popping one expected address/data pair per observed strobe at the falling edge. The `done` and `error` levels are checked at the falling edge of the cycle that carries `done`, and `done` is checked again one cycle later.

// File: rtl/fmu_pkg.sv
package fmu_pkg;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
    localparam int         WORDS_PER_BLK = 4;
    localparam int         LADDR_W = 12;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_HDR_A,
        ST_HDR_B,
        ST_HDR_C,
        ST_WORD,
        ST_BYTE0,
        ST_BYTE1,
        ST_DONE
    } fmu_state_e;

    typedef struct packed {
        logic [7:0] blk;
        logic [3:0] absent;
    } fmu_rec_t;

    function automatic logic is_end_marker(input logic [7:0] h1, input logic [7:0] h2);
        return (h1 == ERASED_BYTE) || (h2 == ERASED_BYTE);
    endfunction

    function automatic fmu_rec_t decode_hdr(input logic [7:0] h1, input logic [7:0] h2);
        fmu_rec_t r;
        r.blk    = {h1[3:0], h2[7:4]};
        r.absent = h2[3:0];
        return r;
    endfunction

    function automatic logic [LADDR_W-1:0] word_offset(input logic [7:0] blk, input logic [1:0] wi);
        return {1'b0, blk, 3'b000} + {9'b0, wi, 1'b0};
    endfunction

endpackage

// File: rtl/fmu_clear_seq.sv
module fmu_clear_seq #(
    parameter int LOG_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [LOG_AW:0]   log_size,
    output logic              active,
    output logic              last,
    output logic [LOG_AW-1:0] addr
);
    localparam int LW = LOG_AW + 1;

    logic [LOG_AW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (go) begin
            active <= (log_size != '0);
            cnt    <= '0;
        end else if (active) begin
            if (last) active <= 1'b0;
            cnt <= cnt + 1'b1;
        end
    end

    assign last = active && ((LW'(cnt) + LW'(1)) == log_size);
    assign addr = cnt;

endmodule

// File: rtl/fmu_bound_chk.sv
module fmu_bound_chk #(
    parameter int PHY_AW = 11,
    parameter int LOG_AW = 10
) (
    input  logic [PHY_AW:0]             idx,
    input  logic [PHY_AW:0]             lim,
    input  logic [fmu_pkg::LADDR_W-1:0] waddr,
    input  logic [LOG_AW:0]             log_size,
    output logic                        phy_bad,
    output logic                        log_bad
);
    localparam int PW = PHY_AW + 2;
    localparam int CW = fmu_pkg::LADDR_W + 1;

    assign phy_bad = (PW'(idx) + PW'(2)) > PW'(lim);
    assign log_bad = (CW'(waddr) + CW'(2)) > CW'(log_size);

endmodule

// File: rtl/fmu_ctrl.sv
module fmu_ctrl
    import fmu_pkg::*;
#(
    parameter int PHY_AW = 11,
    parameter int LOG_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [PHY_AW:0]    sec_size,
    input  logic [PHY_AW:0]    phy_size,
    input  logic               clr_active,
    input  logic               clr_last,
    input  logic [7:0]         phy_rd_data,
    input  logic               phy_bad,
    input  logic               log_bad,
    output logic               clr_go,
    output logic               phy_rd_en,
    output logic [PHY_AW-1:0]  phy_rd_addr,
    output logic               cp_wr_en,
    output logic [LOG_AW-1:0]  cp_wr_addr,
    output logic [7:0]         cp_wr_data,
    output logic [PHY_AW:0]    idx_o,
    output logic [PHY_AW:0]    lim_o,
    output logic [LADDR_W-1:0] waddr_o,
    output logic               busy,
    output logic               done,
    output logic               error
);
    localparam int PW = PHY_AW + 1;

    fmu_state_e         st, nxt;
    logic [PW-1:0]      idx, lim, idx_p1;
    logic [7:0]         hdr1;
    fmu_rec_t           rec;
    logic [2:0]         wi;
    logic [LADDR_W-1:0] waddr, waddr_p1;
    logic               word_absent;

    assign idx_p1      = idx + PW'(1);
    assign waddr       = word_offset(rec.blk, wi[1:0]);
    assign waddr_p1    = waddr + LADDR_W'(1);
    assign word_absent = rec.absent[wi[1:0]];

    always_comb begin
        nxt         = st;
        phy_rd_en   = 1'b0;
        phy_rd_addr = idx[PHY_AW-1:0];
        cp_wr_en    = 1'b0;
        cp_wr_addr  = waddr[LOG_AW-1:0];
        cp_wr_data  = phy_rd_data;
        case (st)
            ST_IDLE:  if (start) nxt = ST_CLEAR;
            ST_CLEAR: if (!clr_active || clr_last) nxt = ST_HDR_A;
            ST_HDR_A: begin
                if (idx >= lim) begin
                    nxt = ST_DONE;
                end else begin
                    phy_rd_en = 1'b1;
                    nxt       = ST_HDR_B;
                end
            end
            ST_HDR_B: begin
                phy_rd_en   = 1'b1;
                phy_rd_addr = idx_p1[PHY_AW-1:0];
                nxt         = ST_HDR_C;
            end
            ST_HDR_C: nxt = is_end_marker(hdr1, phy_rd_data) ? ST_DONE : ST_WORD;
            ST_WORD: begin
                if (wi[2]) begin
                    nxt = ST_HDR_A;
                end else if (word_absent) begin
                    nxt = ST_WORD;
                end else if (phy_bad || log_bad) begin
                    nxt = ST_DONE;
                end else begin
                    phy_rd_en = 1'b1;
                    nxt       = ST_BYTE0;
                end
            end
            ST_BYTE0: begin
                cp_wr_en    = 1'b1;
                phy_rd_en   = 1'b1;
                phy_rd_addr = idx_p1[PHY_AW-1:0];
                nxt         = ST_BYTE1;
            end
            ST_BYTE1: begin
                cp_wr_en   = 1'b1;
                cp_wr_addr = waddr_p1[LOG_AW-1:0];
                nxt        = ST_WORD;
            end
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            idx   <= '0;
            lim   <= '0;
            hdr1  <= '0;
            rec   <= '0;
            wi    <= '0;
            error <= 1'b0;
        end else begin
            st <= nxt;
            case (st)
                ST_IDLE: if (start) begin
                    idx   <= sec_size;
                    lim   <= (phy_size > sec_size) ? (phy_size - sec_size) : '0;
                    error <= 1'b0;
                end
                ST_HDR_B: hdr1 <= phy_rd_data;
                ST_HDR_C: if (!is_end_marker(hdr1, phy_rd_data)) begin
                    rec <= decode_hdr(hdr1, phy_rd_data);
                    idx <= idx + PW'(2);
                    wi  <= '0;
                end
                ST_WORD: if (!wi[2]) begin
                    if (word_absent)               wi    <= wi + 3'd1;
                    else if (phy_bad || log_bad)   error <= 1'b1;
                end
                ST_BYTE1: begin
                    idx <= idx + PW'(2);
                    wi  <= wi + 3'd1;
                end
                default: ;
            endcase
        end
    end

    assign clr_go  = (st == ST_IDLE) && start;
    assign busy    = (st != ST_IDLE);
    assign done    = (st == ST_DONE);
    assign idx_o   = idx;
    assign lim_o   = lim;
    assign waddr_o = waddr;

endmodule

// File: rtl/fuse_map_unpacker.sv
module fuse_map_unpacker #(
    parameter int PHY_AW = 11,
    parameter int LOG_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PHY_AW:0]   sec_size,
    input  logic [PHY_AW:0]   phy_size,
    input  logic [LOG_AW:0]   log_size,
    output logic              phy_rd_en,
    output logic [PHY_AW-1:0] phy_rd_addr,
    input  logic [7:0]        phy_rd_data,
    output logic              log_wr_en,
    output logic [LOG_AW-1:0] log_wr_addr,
    output logic [7:0]        log_wr_data,
    output logic              done,
    output logic              error
);
    logic                            clr_go, clr_active, clr_last;
    logic [LOG_AW-1:0]               clr_addr;
    logic                            cp_wr_en;
    logic [LOG_AW-1:0]               cp_wr_addr;
    logic [7:0]                      cp_wr_data;
    logic [PHY_AW:0]                 idx, lim;
    logic [fmu_pkg::LADDR_W-1:0]     waddr;
    logic                            phy_bad, log_bad;
    logic                            busy;

    fmu_clear_seq #(.LOG_AW(LOG_AW)) u_clear (
        .clk      (clk),
        .rst      (rst),
        .go       (clr_go),
        .log_size (log_size),
        .active   (clr_active),
        .last     (clr_last),
        .addr     (clr_addr)
    );

    fmu_bound_chk #(.PHY_AW(PHY_AW), .LOG_AW(LOG_AW)) u_bound (
        .idx      (idx),
        .lim      (lim),
        .waddr    (waddr),
        .log_size (log_size),
        .phy_bad  (phy_bad),
        .log_bad  (log_bad)
    );

    fmu_ctrl #(.PHY_AW(PHY_AW), .LOG_AW(LOG_AW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .sec_size    (sec_size),
        .phy_size    (phy_size),
        .clr_active  (clr_active),
        .clr_last    (clr_last),
        .phy_rd_data (phy_rd_data),
        .phy_bad     (phy_bad),
        .log_bad     (log_bad),
        .clr_go      (clr_go),
        .phy_rd_en   (phy_rd_en),
        .phy_rd_addr (phy_rd_addr),
        .cp_wr_en    (cp_wr_en),
        .cp_wr_addr  (cp_wr_addr),
        .cp_wr_data  (cp_wr_data),
        .idx_o       (idx),
        .lim_o       (lim),
        .waddr_o     (waddr),
        .busy        (busy),
        .done        (done),
        .error       (error)
    );

    // erase traffic owns the port while active; decoded copies follow
    always_comb begin
        if (clr_active) begin
            log_wr_en   = 1'b1;
            log_wr_addr = clr_addr;
            log_wr_data = fmu_pkg::ERASED_BYTE;
        end else begin
            log_wr_en   = cp_wr_en;
            log_wr_addr = cp_wr_addr;
            log_wr_data = cp_wr_data;
        end
    end

endmodule

// File: rtl/fmu_checker.sv
module fmu_checker #(
    parameter int PHY_AW = 11,
    parameter int LOG_AW = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              phy_rd_en,
    input logic              log_wr_en,
    input logic [LOG_AW-1:0] log_wr_addr,
    input logic [LOG_AW:0]   log_size
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    wr_range_chk: assert property (@(posedge clk) disable iff (rst)
        log_wr_en |-> ({1'b0, log_wr_addr} < log_size));

    // R9
    err_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> done);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (error && !start) |=> error);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!log_wr_en && !phy_rd_en));

endmodule

bind fuse_map_unpacker fmu_checker #(.PHY_AW(PHY_AW), .LOG_AW(LOG_AW)) u_fmu_checker (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .phy_rd_en   (phy_rd_en),
    .log_wr_en   (log_wr_en),
    .log_wr_addr (log_wr_addr),
    .log_size    (log_size)
);

// File: tb/fuse_map_unpacker_test.sv
module fuse_map_unpacker_test;
    localparam int PHY_AW = 11;
    localparam int LOG_AW = 10;
    localparam int PDEPTH = 1 << PHY_AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [PHY_AW:0]   sec_size = '0;
    logic [PHY_AW:0]   phy_size = '0;
    logic [LOG_AW:0]   log_size = '0;
    logic              phy_rd_en;
    logic [PHY_AW-1:0] phy_rd_addr;
    logic [7:0]        phy_rd_data = '0;
    logic              log_wr_en;
    logic [LOG_AW-1:0] log_wr_addr;
    logic [7:0]        log_wr_data;
    logic              done, error;

    logic [7:0] mem [PDEPTH];
    int exp_q[$];
    int checks = 0, fails = 0;
    int writes_seen = 0, first_copy = -1, cur_lsz = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    fuse_map_unpacker #(.PHY_AW(PHY_AW), .LOG_AW(LOG_AW)) uut (.*);

    // physical RAM model, one-cycle latency (R10)
    always @(posedge clk) if (phy_rd_en) phy_rd_data <= mem[phy_rd_addr];

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && log_wr_en) begin
            if (exp_q.size() == 0) begin
                check({cur_tag, " unexpected write"}, int'(log_wr_addr), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check({cur_tag, " write addr"}, int'(log_wr_addr), e >> 8);
                check({cur_tag, " write data"}, int'(log_wr_data), e & 255);
            end
            if (writes_seen == cur_lsz && first_copy < 0) first_copy = int'(log_wr_addr);
            writes_seen++;
        end
    end

    task automatic erase_mem();
        for (int i = 0; i < PDEPTH; i++) mem[i] = 8'hFF;
    endtask

    task automatic put_rec(int at, logic [7:0] h1, logic [7:0] h2, int nwords);
        mem[at]     = h1;
        mem[at + 1] = h2;
        for (int k = 0; k < 2 * nwords; k++) mem[at + 2 + k] = 8'((at + k) * 13 + 5);
    endtask

    // driver side: expected write stream from the requirements
    task automatic model(int sec, int phy, int lsz, output bit err);
        int idx, lim, blk, la;
        logic [7:0] h1, h2;
        err = 0;
        for (int a = 0; a < lsz; a++) exp_q.push_back((a << 8) | 255);   // R1
        lim = (phy > sec) ? phy - sec : 0;                               // R2
        idx = sec;
        while (idx < lim) begin
            h1 = mem[idx];
            h2 = mem[(idx + 1) % PDEPTH];
            if (h1 == 8'hFF || h2 == 8'hFF) break;                       // R3
            blk = {h1[3:0], h2[7:4]};                                    // R4
            idx += 2;
            for (int i = 0; i < 4; i++) begin
                if (h2[i]) continue;                                     // R5
                la = blk * 8 + i * 2;                                    // R6
                if (idx + 2 > lim || la + 2 > lsz) begin err = 1; return; end   // R7 R8
                exp_q.push_back((la << 8) | mem[idx]);
                exp_q.push_back(((la + 1) << 8) | mem[idx + 1]);
                idx += 2;
            end
        end
    endtask

    task automatic run(string tag, int sec, int phy, int lsz, bit extra);
        bit exp_err;
        int n;
        exp_q.delete();
        sec_size = (PHY_AW+1)'(sec);
        phy_size = (PHY_AW+1)'(phy);
        log_size = (LOG_AW+1)'(lsz);
        cur_lsz = lsz; writes_seen = 0; first_copy = -1; cur_tag = tag;
        model(sec, phy, lsz, exp_err);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check({tag, " R9 error cleared after start"}, int'(error), 0);
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
            start = extra && (n == 5 || n == 100);   // R11 ignored while busy
        end
        start = 1'b0;
        check({tag, " done seen"}, int'(done), 1);
        check({tag, " error level"}, int'(error), int'(exp_err));
        check({tag, " all expected writes"}, exp_q.size(), 0);
        @(negedge clk);
        check({tag, " R9 done one cycle"}, int'(done), 0);
        check({tag, " R9 error held"}, int'(error), int'(exp_err));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        erase_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset done", int'(done), 0);
        check("R11 reset error", int'(error), 0);
        check("R11 reset wr_en", int'(log_wr_en), 0);
        check("R11 reset rd_en", int'(phy_rd_en), 0);

        // R2 R5 R6: start at reserved offset; decoy record below it
        erase_mem();
        put_rec(0, 8'h00, 8'h00, 4);
        put_rec(16, 8'h00, 8'h20, 4);
        put_rec(26, 8'h01, 8'h5A, 2);
        run("R2_R5_R6", 16, 512, 256, 0);

        // R4 R3: split index, ignored upper nibble, all-absent record, end marker in byte 2
        erase_mem();
        put_rec(0, 8'h03, 8'h5E, 1);
        put_rec(4, 8'h00, 8'h0F, 0);
        put_rec(6, 8'hA1, 8'h07, 1);
        mem[10] = 8'h00; mem[11] = 8'hFF;
        run("R4_R3", 0, 64, 512, 0);
        check("R4 first decoded address", first_copy, 424);

        // R7: word overruns physical window
        erase_mem();
        put_rec(8, 8'h00, 8'h00, 4);
        put_rec(18, 8'h00, 8'h10, 4);
        put_rec(28, 8'h00, 8'h20, 4);
        run("R7", 8, 40, 256, 0);

        // R9 R11: start after error, extra start pulses while busy
        erase_mem();
        put_rec(16, 8'h00, 8'h20, 4);
        put_rec(26, 8'h01, 8'h5A, 2);
        run("R9_R11", 16, 512, 256, 1);

        // R8: last slot of the map fits, the next block does not
        erase_mem();
        put_rec(0, 8'h00, 8'h70, 4);
        put_rec(10, 8'h00, 8'h8E, 1);
        run("R8", 0, 128, 64, 0);

        // R2: window consumed exactly at a record boundary
        erase_mem();
        put_rec(4, 8'h00, 8'h30, 4);
        put_rec(14, 8'h00, 8'h4F, 0);
        mem[16] = 8'h00; mem[17] = 8'h00;
        run("R2_exact_end", 4, 20, 128, 0);

        // R1 R8: empty logical map, no erase writes, any word is out of range
        erase_mem();
        put_rec(0, 8'h00, 8'h0E, 1);
        run("R1_empty_map", 0, 16, 0, 0);

        // R2: reserved region swallows the image
        erase_mem();
        put_rec(0, 8'h00, 8'h00, 4);
        run("R2_no_window", 32, 40, 16, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule